// File: doc/BRIEF.md
# Barrel Shifter with Carry-Out

This block is a purely combinational 32-bit shift unit for a processor execute stage. From a data operand, a 3-bit shift kind, an 8-bit shift amount and the current carry flag, it forms the shifted word, the new carry value and a strobe that tells the flag logic whether the carry should be written. The same path serves immediate-form shifts, whose amounts are small constants, and register-form shifts, whose amount is the low byte of a register and may be anywhere from 0 to 255.

The carry output is the last bit moved out of the word. Every shift kind has a defined result and carry for an amount of zero and for amounts of 32 or more. A one-bit rotate through the carry is also available. Internally, all kinds share one right-shifting network over a 65-bit extended vector. Left shifts reuse it by reversing the bit order. The extra low guard bit of the vector collects the carry.

Top module: `barrel_shift_carry`

## Requirements
- R1: Shift kind codes on `kind_i` are: 0 logical left, 1 logical right, 2 arithmetic right, 3 rotate right, 4 rotate right one bit through carry. Codes 5, 6 and 7 behave exactly like code 0.
- R2: For every kind except code 4, an amount of zero returns the operand unchanged, passes `carry_i` to `carry_o`, and holds `carry_we_o` low.
- R3: Logical left by n from 1 to 32 gives the operand shifted up n places with zeros filled below, and carry equal to operand bit 32-n. For n above 32, both the result and the carry are zero.
- R4: Logical right by n from 1 to 31 gives the operand moved down n places with zeros filled above, and carry equal to operand bit n-1.
- R5: Logical right by exactly 32 gives a zero result with carry equal to operand bit 31. Above 32, both the result and the carry are zero.
- R6: Arithmetic right by n from 1 to 31 fills the top n bits with operand bit 31 and moves the rest down n places. The carry equals operand bit n-1.
- R7: Arithmetic right by 32 or more sets every result bit to operand bit 31, and the carry also equals operand bit 31.
- R8: Rotate right by a nonzero amount whose low five bits are nonzero rotates by the amount modulo 32. The carry equals result bit 31.
- R9: Rotate right by a nonzero multiple of 32 returns the operand unchanged, with carry equal to operand bit 31.
- R10: Code 4 ignores the amount. The result is `carry_i` followed by operand bits 31 down to 1, and the carry is operand bit 0.
- R11: `carry_we_o` is high exactly when the amount is nonzero or the kind is code 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| operand_i | input | 32 | Value to be shifted |
| kind_i | input | 3 | Shift kind code (see R1) |
| amount_i | input | 8 | Shift amount, 0 to 255 |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted value |
| carry_o | output | 1 | New carry value |
| carry_we_o | output | 1 | Carry should be written |

## Verification
The block holds no state, so a faulty internal signal appears at the ports in the same evaluation as the input that exposes it. A wrong guard bit or fill bit in the extended vector shows up only at the boundaries: amount 32, amounts above 32, and rotations by a multiple of 32. A bad mirror control shows up only for left shifts. The stimulus therefore places directed vectors at those boundaries and adds random amounts over the full 0 to 255 range for every kind code.

// File: rtl/bsh_pkg.sv
package bsh_pkg;

  typedef enum logic [2:0] {
    SK_LSL = 3'd0,
    SK_LSR = 3'd1,
    SK_ASR = 3'd2,
    SK_ROR = 3'd3,
    SK_RRX = 3'd4
  } shift_kind_e;

  // Bit-order reversal used to turn a left shift into a right shift.
  function automatic logic [31:0] mirror32(input logic [31:0] v);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[i] = v[31-i];
    return r;
  endfunction

  // True when the amount reaches or passes the word width.
  function automatic logic reaches_width(input logic [7:0] amt, input int width);
    return int'(amt) >= width;
  endfunction

endpackage

// File: rtl/bsh_right_core.sv
// Logarithmic right shifter over an extended vector. Each stage shifts by a
// power of two and fills the vacated top bits with fill_i.
module bsh_right_core #(
  parameter int VEC_W = 65,
  parameter int AMT_W = 8,
  parameter int OUT_W = 33
) (
  input  logic [VEC_W-1:0] vec_i,
  input  logic             fill_i,
  input  logic [AMT_W-1:0] amt_i,
  output logic [OUT_W-1:0] shifted_o
);

  logic [VEC_W-1:0] stage_q [AMT_W+1];

  assign stage_q[0] = vec_i;

  for (genvar s = 0; s < AMT_W; s++) begin : g_stage
    localparam int SH = 1 << s;
    logic [VEC_W-1:0] moved;
    if (SH >= VEC_W) begin : g_flood
      assign moved = {VEC_W{fill_i}};
    end else begin : g_part
      assign moved = {{SH{fill_i}}, stage_q[s][VEC_W-1:SH]};
    end
    assign stage_q[s+1] = amt_i[s] ? moved : stage_q[s];
  end

  assign shifted_o = stage_q[AMT_W][OUT_W-1:0];

endmodule

// File: rtl/bsh_ctrl.sv
// Builds the extended vector {upper, operand, guard} and the effective amount
// for each shift kind.
module bsh_ctrl
  import bsh_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0]   operand_i,
  input  logic [2:0]          kind_i,
  input  logic [AMT_W-1:0]    amount_i,
  input  logic                carry_i,
  output logic [2*DATA_W:0]   vec_o,
  output logic                fill_o,
  output logic [AMT_W-1:0]    amt_o,
  output logic                mirror_o,
  output logic                zero_shift_o
);

  localparam int LOG_W = $clog2(DATA_W);

  shift_kind_e kind;
  assign kind = shift_kind_e'(kind_i);

  always_comb begin
    vec_o    = {{DATA_W{1'b0}}, operand_i, 1'b0};
    fill_o   = 1'b0;
    amt_o    = amount_i;
    mirror_o = 1'b0;
    case (kind)
      SK_LSR: begin
        vec_o = {{DATA_W{1'b0}}, operand_i, 1'b0};
      end
      SK_ASR: begin
        vec_o  = {{DATA_W{operand_i[DATA_W-1]}}, operand_i, 1'b0};
        fill_o = operand_i[DATA_W-1];
      end
      SK_ROR: begin
        // Guard bit carries operand MSB so a wrapped rotation yields it as carry.
        vec_o = {operand_i, operand_i, operand_i[DATA_W-1]};
        amt_o = {{(AMT_W-LOG_W){1'b0}}, amount_i[LOG_W-1:0]};
      end
      SK_RRX: begin
        vec_o = {{(DATA_W-1){1'b0}}, carry_i, operand_i, 1'b0};
        amt_o = AMT_W'(1);
      end
      default: begin
        vec_o    = {{DATA_W{1'b0}}, mirror32(operand_i), 1'b0};
        mirror_o = 1'b1;
      end
    endcase
  end

  assign zero_shift_o = (amount_i == '0) && (kind != SK_RRX);

endmodule

// File: rtl/barrel_shift_carry.sv
module barrel_shift_carry
  import bsh_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] operand_i,
  input  logic [2:0]        kind_i,
  input  logic [AMT_W-1:0]  amount_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] result_o,
  output logic              carry_o,
  output logic              carry_we_o
);

  localparam int VEC_W = 2 * DATA_W + 1;
  localparam int OUT_W = DATA_W + 1;
  localparam int LOG_W = $clog2(DATA_W);

  logic [VEC_W-1:0] ext_vec;
  logic             ext_fill;
  logic [AMT_W-1:0] eff_amt;
  logic             use_mirror;
  logic             is_zero_shift;
  logic [OUT_W-1:0] core_out;
  logic [DATA_W-1:0] raw_word;
  logic [DATA_W-1:0] shaped_word;
  logic             is_big_amt;
  logic             is_ror_wrap;

  bsh_ctrl #(.DATA_W(DATA_W), .AMT_W(AMT_W)) i_ctrl (
    .operand_i    (operand_i),
    .kind_i       (kind_i),
    .amount_i     (amount_i),
    .carry_i      (carry_i),
    .vec_o        (ext_vec),
    .fill_o       (ext_fill),
    .amt_o        (eff_amt),
    .mirror_o     (use_mirror),
    .zero_shift_o (is_zero_shift)
  );

  bsh_right_core #(.VEC_W(VEC_W), .AMT_W(AMT_W), .OUT_W(OUT_W)) i_core (
    .vec_i     (ext_vec),
    .fill_i    (ext_fill),
    .amt_i     (eff_amt),
    .shifted_o (core_out)
  );

  assign raw_word    = core_out[DATA_W:1];
  assign shaped_word = use_mirror ? mirror32(raw_word) : raw_word;
  assign is_big_amt  = reaches_width(amount_i, DATA_W);
  assign is_ror_wrap = (amount_i != '0) && (amount_i[LOG_W-1:0] == '0);

  assign result_o   = is_zero_shift ? operand_i : shaped_word;
  assign carry_o    = is_zero_shift ? carry_i : core_out[0];
  assign carry_we_o = ~is_zero_shift;

  // Checks against the port-level rules.
  always_comb begin
    if (is_zero_shift) begin
      a_r2_zero_pass: assert (result_o == operand_i && carry_o == carry_i && !carry_we_o);
    end
    if (kind_i == SK_LSR && is_big_amt) begin
      a_r5_lsr_clear: assert (result_o == '0);
    end
    if (kind_i == SK_ASR && is_big_amt) begin
      a_r7_asr_flood: assert (result_o == {DATA_W{operand_i[DATA_W-1]}}
                              && carry_o == operand_i[DATA_W-1]);
    end
    if (kind_i == SK_ROR && amount_i != '0) begin
      a_r8_ror_carry: assert (carry_o == result_o[DATA_W-1]);
    end
    if (kind_i == SK_ROR && is_ror_wrap) begin
      a_r9_ror_wrap: assert (result_o == operand_i);
    end
    if (kind_i == SK_RRX) begin
      a_r10_rrx: assert (result_o[DATA_W-1] == carry_i && carry_o == operand_i[0]
                         && carry_we_o);
    end
  end

endmodule

// File: tb/test_barrel_shift_carry.sv
module test_barrel_shift_carry;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] op;
  logic [2:0]  kind;
  logic [7:0]  amt;
  logic        cin;
  logic [31:0] res;
  logic        cout;
  logic        cwe;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  barrel_shift_carry i_barrel_shift_carry (
    .operand_i  (op),
    .kind_i     (kind),
    .amount_i   (amt),
    .carry_i    (cin),
    .result_o   (res),
    .carry_o    (cout),
    .carry_we_o (cwe)
  );

  // Independent model: wide-integer arithmetic.
  function automatic void model(input logic [31:0] o, input logic [2:0] k,
                                input logic [7:0] n, input logic c,
                                output logic [31:0] r, output logic co,
                                output logic we);
    logic [63:0] w;
    logic signed [63:0] sw;
    int rr;
    we = (n != 0) || (k == 3'd4);
    if (n == 0 && k != 3'd4) begin
      r = o; co = c;
      return;
    end
    case (k)
      3'd1: begin w = {o, 32'h0} >> n; r = w[63:32]; co = w[31]; end
      3'd2: begin
        sw = $signed({o, 32'h0}) >>> ((n > 63) ? 63 : n);
        r = sw[63:32]; co = sw[31];
      end
      3'd3: begin
        rr = int'(n) % 32;
        w = {o, o} >> rr; r = w[31:0]; co = r[31];
      end
      3'd4: begin r = {c, o[31:1]}; co = o[0]; end
      default: begin w = {32'h0, o} << n; r = w[31:0]; co = w[32]; end
    endcase
  endfunction

  function automatic string req_tag(input logic [2:0] k, input logic [7:0] n);
    if (k == 3'd4) return "R10";
    if (n == 0) return "R2";
    case (k)
      3'd1: return (n >= 32) ? "R5" : "R4";
      3'd2: return (n >= 32) ? "R7" : "R6";
      3'd3: return (n[4:0] == 0) ? "R9" : "R8";
      3'd0: return "R3";
      default: return "R1";
    endcase
  endfunction

  task automatic apply(input logic [31:0] o, input logic [2:0] k,
                       input logic [7:0] n, input logic c);
    logic [31:0] er;
    logic ec, ewe;
    string t;
    @(posedge clk);
    op = o; kind = k; amt = n; cin = c;
    @(negedge clk);
    model(o, k, n, c, er, ec, ewe);
    t = req_tag(k, n);
    n_checks++;
    if (res !== er) begin
      n_fail++;
      $display("FAIL %s result kind=%0d amt=%0d op=%h: got %h expected %h", t, k, n, o, res, er);
    end
    n_checks++;
    if (cout !== ec) begin
      n_fail++;
      $display("FAIL %s carry kind=%0d amt=%0d op=%h: got %b expected %b", t, k, n, o, cout, ec);
    end
    n_checks++;
    if (cwe !== ewe) begin
      n_fail++;
      $display("FAIL R11 write strobe kind=%0d amt=%0d: got %b expected %b", k, n, cwe, ewe);
    end
  endtask

  initial begin
    op = '0; kind = '0; amt = '0; cin = 1'b0;
    #1;
    void'($urandom(32'd20240611));
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    // Idle state: all-zero inputs give zero outputs and no write (R2).
    @(negedge clk);
    n_checks++;
    if (res !== 32'h0 || cout !== 1'b0 || cwe !== 1'b0) begin
      n_fail++;
      $display("FAIL R2 idle: got %h/%b/%b expected 0/0/0", res, cout, cwe);
    end
    // Directed corners.
    apply(32'h8000_0001, 3'd0, 8'd0, 1'b1);   // R2
    apply(32'h8000_0001, 3'd2, 8'd0, 1'b0);   // R2
    apply(32'h8000_0001, 3'd0, 8'd1, 1'b0);   // R3
    apply(32'h0000_0001, 3'd0, 8'd32, 1'b0);  // R3 n=32
    apply(32'hFFFF_FFFF, 3'd0, 8'd33, 1'b1);  // R3 n>32
    apply(32'hF000_000F, 3'd1, 8'd4, 1'b0);   // R4
    apply(32'h8000_0000, 3'd1, 8'd32, 1'b0);  // R5
    apply(32'hFFFF_FFFF, 3'd1, 8'd33, 1'b1);  // R5
    apply(32'h8000_0010, 3'd2, 8'd5, 1'b0);   // R6
    apply(32'h8000_0000, 3'd2, 8'd32, 1'b0);  // R7
    apply(32'h7FFF_FFFF, 3'd2, 8'd200, 1'b1); // R7
    apply(32'h8000_0000, 3'd2, 8'd255, 1'b0); // R7
    apply(32'h1234_5679, 3'd3, 8'd8, 1'b0);   // R8
    apply(32'h1234_5679, 3'd3, 8'd35, 1'b0);  // R8
    apply(32'h8000_0000, 3'd3, 8'd32, 1'b0);  // R9
    apply(32'h7FFF_FFFF, 3'd3, 8'd64, 1'b1);  // R9
    apply(32'h0000_0003, 3'd4, 8'd0, 1'b1);   // R10
    apply(32'h0000_0002, 3'd4, 8'd77, 1'b0);  // R10 amount ignored
    apply(32'hC000_0001, 3'd5, 8'd2, 1'b0);   // R1
    apply(32'hC000_0001, 3'd7, 8'd31, 1'b0);  // R1
    // Random mix across all codes and amounts.
    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      a = 8'($urandom);
      if (i % 4 == 0) a = a & 8'h3F;
      apply($urandom, 3'($urandom), a, 1'($urandom));
    end
    finished = 1;
  end

  initial begin
    fork
      wait (finished);
      begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
      end
    join_any
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule